// File: doc/BRIEF.md
# Multiplexed-Bus Memory Select Decoder

This block produces the memory selects for an 8-bit processor that sends its 16-bit address in two halves over one 8-bit address bus. The upper byte is placed on the bus first, together with a high-byte strobe. The block keeps that byte and then combines it with the lower byte, which is presented while an active-low read or write is in progress. The built-in 2 KB ROM is split into four 512-byte regions. Each region has a match flag and a read enable. The 512 bytes of RAM sit in two 256-byte banks, each with its own select, and share one output-enable and one write-enable.

ROM regions claim addresses by comparing the kept upper address bits against a base address given as a parameter. RAM is selected only by exclusion: it is enabled wherever no ROM region matches, upper-address bit 9 is low, and the external cartridge select is low. As a result, RAM is mirrored across the map. An active-low cartridge-disable input switches off the two game regions so that an external ROM can answer in their place.

Top module: `memdec_top`

## Requirements
- R1: While `tpa_i` is high, `addr_i` is taken as address bits 15..8 and the decode follows it in the same cycle. After `tpa_i` falls, that byte is held while the low byte and further bus values are on `addr_i`.
- R2: After reset the held upper byte is 0x00, so with `tpa_i` low only region 0 is flagged (`rom_match_o` = 4'b0001) and every enable is 0.
- R3: `rom_match_o[k]` is 1 exactly when address bits 15..9 equal those of region k's base. The default bases are 0x0000, 0x0200, 0x0400 and 0x0600 for k = 0..3.
- R4: `rom_ce_o[k]` is 1 only when `rom_match_o[k]` is 1 and `mrd_ni` is 0. A write gives no ROM enable.
- R5: When `cart_dis_ni` is 0, regions 2 and 3 (0x400–0x7FF) give neither a match nor an enable. Regions 0 and 1 are unaffected.
- R6: RAM is selected only when no ROM region matches, address bit 9 is 0, and `cart_sel_i` is 0.
- R7: When RAM is selected, address bit 8 picks the bank: 0 raises `ram_cs_o[0]`, 1 raises `ram_cs_o[1]`. At most one bank select is ever high.
- R8: `ram_oe_o` is 1 only while RAM is selected and `mrd_ni` is 0. `ram_we_o` is 1 only while RAM is selected and `mwr_ni` is 0.
- R9: With the cartridge idle, RAM answers at 0x800–0x9FF, again at 0xC00–0xDFF, and at every address above 0xFFF whose bit 9 is 0.
- R10: With `cart_dis_ni` high and `cart_sel_i` low, a read at 0xA00–0xBFF or 0xE00–0xFFF raises no ROM enable and no RAM output-enable, so nothing drives the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the held upper address byte |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Multiplexed address bus: high byte, then low byte |
| tpa_i | input | 1 | High-byte strobe |
| mrd_ni | input | 1 | Memory read, active low |
| mwr_ni | input | 1 | Memory write, active low |
| cart_dis_ni | input | 1 | Disables the built-in game ROM regions when low |
| cart_sel_i | input | 1 | External cartridge ROM claims the current address |
| rom_match_o | output | 4 | Address match flag per ROM region |
| rom_ce_o | output | 4 | Read enable per ROM region |
| ram_cs_o | output | 2 | RAM bank selects |
| ram_oe_o | output | 1 | RAM output enable |
| ram_we_o | output | 1 | RAM write enable |

## Verification
Reads land in each ROM region at its first and last byte, which separates the region borders on bit 9 from the RAM bank split on bit 8. RAM is reached at its base window, at the 0xC00 mirror and at high mirrors, and accesses at 0xA00, 0xBFF and 0xE55 expose any decode that ignores bit 9. A write to ROM and an idle cycle inside RAM separate the select from the read and write strobes. Runs with the cartridge disable low and the cartridge select high show that only the game regions yield, and that the external select removes RAM. After the strobe falls, the bus is changed a second time; this catches a high byte that is not held.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/memdec_hi_latch.sv
module memdec_hi_latch
  import memdec_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  strobe_i,
  input  byte_t bus_i,
  output byte_t hi_o
);
  byte_t hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hold_q <= '0;
    else if (strobe_i) hold_q <= bus_i;
  end

  // transparent while strobe high
  assign hi_o = strobe_i ? bus_i : hold_q;

  // R1
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(hold_q));

  // R1
  hold_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (hold_q == $past(bus_i)));
endmodule

// File: rtl/memdec_rom_match.sv
module memdec_rom_match
  import memdec_pkg::*;
#(
  parameter int                        NUM_REGIONS = 4,
  parameter int                        SPAN_W      = 9,
  parameter logic [NUM_REGIONS*16-1:0] REGION_BASE = {16'h0600, 16'h0400, 16'h0200, 16'h0000},
  parameter logic [NUM_REGIONS-1:0]    GATED_MASK  = 4'b1100,
  localparam int                       CMP_W       = ADDR_W - SPAN_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [CMP_W-1:0]       hi_tag_i,
  input  logic                   gated_en_i,
  input  logic                   mrd_ni,
  output logic [NUM_REGIONS-1:0] match_o,
  output logic [NUM_REGIONS-1:0] ce_o
);
  for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_region
    logic hit;
    assign hit = (hi_tag_i == REGION_BASE[k*16+15 -: CMP_W]);
    if (GATED_MASK[k]) begin : g_gated
      assign match_o[k] = hit & gated_en_i;
    end else begin : g_fixed
      assign match_o[k] = hit;
    end
    assign ce_o[k] = match_o[k] & ~mrd_ni;
  end

  // R5
  gated_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gated_en_i |-> ((match_o & GATED_MASK) == '0));

  // R4
  rom_ce_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrd_ni |-> (ce_o == '0));

  // R3
  rom_single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_o));
endmodule

// File: rtl/memdec_ram_sel.sv
module memdec_ram_sel
  import memdec_pkg::*;
#(
  parameter int  NUM_BANKS = 2,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BANK_W:0]      hi_low_i,   // [BANK_W] is the block-exclude bit
  input  logic                 any_rom_i,
  input  logic                 cart_sel_i,
  input  logic                 mrd_ni,
  input  logic                 mwr_ni,
  output logic [NUM_BANKS-1:0] cs_o,
  output logic                 oe_o,
  output logic                 we_o
);
  logic sel;

  // wired-OR exclusion: any claimant removes RAM
  assign sel = ~(any_rom_i | hi_low_i[BANK_W] | cart_sel_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign cs_o[b] = sel & (hi_low_i[BANK_W-1:0] == BANK_W'(b));
  end

  assign oe_o = sel & ~mrd_ni;
  assign we_o = sel & ~mwr_ni;

  // R7
  bank_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));

  // R6
  ram_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cs_o) |-> (!any_rom_i && !cart_sel_i));

  // R8
  ram_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> (!mrd_ni && (|cs_o)));

  // R8
  ram_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (!mwr_ni && (|cs_o)));
endmodule

// File: rtl/memdec_top.sv
module memdec_top
  import memdec_pkg::*;
#(
  parameter int                        NUM_REGIONS = 4,
  parameter int                        SPAN_W      = 9,
  parameter logic [NUM_REGIONS*16-1:0] REGION_BASE = {16'h0600, 16'h0400, 16'h0200, 16'h0000},
  parameter logic [NUM_REGIONS-1:0]    GATED_MASK  = 4'b1100,
  parameter int                        NUM_BANKS   = 2,
  localparam int                       CMP_W       = ADDR_W - SPAN_W,
  localparam int                       BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [BYTE_W-1:0]      addr_i,
  input  logic                   tpa_i,
  input  logic                   mrd_ni,
  input  logic                   mwr_ni,
  input  logic                   cart_dis_ni,
  input  logic                   cart_sel_i,
  output logic [NUM_REGIONS-1:0] rom_match_o,
  output logic [NUM_REGIONS-1:0] rom_ce_o,
  output logic [NUM_BANKS-1:0]   ram_cs_o,
  output logic                   ram_oe_o,
  output logic                   ram_we_o
);
  byte_t hi;

  memdec_hi_latch i_hi_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (tpa_i),
    .bus_i    (addr_i),
    .hi_o     (hi)
  );

  memdec_rom_match #(
    .NUM_REGIONS (NUM_REGIONS),
    .SPAN_W      (SPAN_W),
    .REGION_BASE (REGION_BASE),
    .GATED_MASK  (GATED_MASK)
  ) i_rom_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hi_tag_i   (hi[BYTE_W-1 -: CMP_W]),
    .gated_en_i (cart_dis_ni),
    .mrd_ni     (mrd_ni),
    .match_o    (rom_match_o),
    .ce_o       (rom_ce_o)
  );

  memdec_ram_sel #(
    .NUM_BANKS (NUM_BANKS)
  ) i_ram_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hi_low_i   (hi[BANK_W:0]),
    .any_rom_i  (|rom_match_o),
    .cart_sel_i (cart_sel_i),
    .mrd_ni     (mrd_ni),
    .mwr_ni     (mwr_ni),
    .cs_o       (ram_cs_o),
    .oe_o       (ram_oe_o),
    .we_o       (ram_we_o)
  );

  // R10
  bus_single_driver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|rom_ce_o) && ram_oe_o));

  // R9
  ram_needs_bit9_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ram_cs_o) |-> !hi[BANK_W]);
endmodule

// File: tb/test_memdec_top.sv
module test_memdec_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       tpa = 1'b0;
  logic       mrd_n = 1'b1;
  logic       mwr_n = 1'b1;
  logic       cart_dis_n = 1'b1;
  logic       cart_sel = 1'b0;
  logic [3:0] rom_match, rom_ce;
  logic [1:0] ram_cs;
  logic       ram_oe, ram_we;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memdec_top i_memdec_top (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .addr_i      (addr),
    .tpa_i       (tpa),
    .mrd_ni      (mrd_n),
    .mwr_ni      (mwr_n),
    .cart_dis_ni (cart_dis_n),
    .cart_sel_i  (cart_sel),
    .rom_match_o (rom_match),
    .rom_ce_o    (rom_ce),
    .ram_cs_o    (ram_cs),
    .ram_oe_o    (ram_oe),
    .ram_we_o    (ram_we)
  );

  // behavioural reference: {match, ce, cs, oe, we}
  function automatic logic [11:0] model(int a, bit rd, bit wr, bit cdn, bit cs);
    logic [3:0] m = '0;
    logic [1:0] bank = '0;
    bit ram;
    for (int k = 0; k < 4; k++)
      if (a >= k*512 && a < (k+1)*512 && !(k >= 2 && !cdn)) m[k] = 1'b1;
    ram = (m == 0) && (((a >> 9) & 1) == 0) && !cs;
    if (ram) bank = ((a >> 8) & 1) != 0 ? 2'b10 : 2'b01;
    return {m, (rd ? m : 4'b0), bank, 1'(ram && rd), 1'(ram && wr)};
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] outs();
    return {rom_match, rom_ce, ram_cs, ram_oe, ram_we};
  endfunction

  task automatic access(int a, bit rd, bit wr, bit cdn, bit cs, string tag);
    logic [11:0] exp;
    exp = model(a, rd, wr, cdn, cs);
    @(negedge clk);
    addr = 8'(a >> 8); tpa = 1'b1; mrd_n = 1'b1; mwr_n = 1'b1;
    cart_dis_n = cdn; cart_sel = cs;
    #1;
    // R1 transparency: match follows bus during strobe
    check({tag, " R1 transparent"}, {rom_match, rom_ce}, {exp[11:8], 4'b0});
    @(negedge clk);
    tpa = 1'b0; addr = 8'(a); mrd_n = !rd; mwr_n = !wr;
    #1;
    check(tag, outs(), exp);
    #2 addr = ~8'(a);
    #1;
    check({tag, " R1 hold"}, outs(), exp);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R2 in reset", outs(), {4'b0001, 4'b0, 2'b0, 1'b0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R2 after reset", outs(), {4'b0001, 4'b0, 2'b0, 1'b0, 1'b0});

    access('h0000, 1, 0, 1, 0, "R3 R4 region0 low");
    access('h01FF, 1, 0, 1, 0, "R3 region0 top");
    access('h0200, 1, 0, 1, 0, "R3 region1 base");
    access('h0456, 1, 0, 1, 0, "R3 region2");
    access('h07FF, 1, 0, 1, 0, "R3 region3 top");
    access('h0123, 0, 1, 1, 0, "R4 write to rom");
    access('h0456, 1, 0, 0, 0, "R5 disable gives ram");
    access('h0456, 1, 0, 0, 1, "R5 R6 cart select");
    access('h0700, 1, 0, 0, 0, "R5 region3 off");
    access('h0345, 1, 0, 0, 0, "R5 region1 kept");
    access('h0800, 1, 0, 1, 0, "R7 R8 ram bank0 read");
    access('h09AB, 0, 1, 1, 0, "R7 R8 ram bank1 write");
    access('h0850, 0, 0, 1, 0, "R8 ram idle");
    access('h0800, 1, 0, 1, 1, "R6 cart select blocks ram");
    access('h0C10, 1, 0, 1, 0, "R9 mirror C00");
    access('h0DFF, 0, 1, 1, 0, "R9 mirror DFF");
    access('h1100, 1, 0, 1, 0, "R9 high mirror");
    access('hF0EE, 1, 0, 1, 0, "R9 top mirror");
    access('h3300, 1, 0, 1, 0, "R9 bit9 high none");
    access('h0A00, 1, 0, 1, 0, "R10 A00");
    access('h0BFF, 1, 0, 1, 0, "R10 BFF");
    access('h0E55, 1, 0, 1, 0, "R10 E55");
    access('h0FFF, 0, 1, 1, 0, "R10 FFF write");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule